// File: doc/BRIEF.md
# SPI Master Byte Engine

This block is a byte-wide SPI master that sits behind a plain register-style host port. A host write to the data input starts one full-duplex transfer of eight bits. The block shifts the byte out on MOSI and, during the same transfer, captures the byte arriving on MISO. At the end of the transfer the received byte appears on the read-data output.

The serial clock comes from a programmable divider of the system clock. One half-bit lasts `baud_div + 1` system clock cycles. The clock idle level, the sampling edge and the bit order are chosen by static configuration inputs. The block latches phase and order when each byte starts.

The write side has room for one extra byte while a transfer runs. The transmit interrupt fires when the waiting byte is taken into the shifter. This is about eight bit periods before the matching receive interrupt. The block drives no slave-select line. Any select the external device needs comes from a general-purpose pin.

Top module: `spi_byte_master`

## Requirements
- R1: A write accepted at clock edge E moves the byte into the shifter at edge E+1. At that edge `busy` rises. The transfer lasts 16*(baud_div+1) cycles: `rx_irq` is high in the cycle after edge E+1+16*(baud_div+1).
- R2: Each transfer sends eight bits on `mosi` and captures eight bits from `miso`. The captured byte is loaded into `rd_data` at the final edge, and `rx_irq` pulses for one cycle at the same time.
- R3: `sck` makes exactly 16 transitions per byte, one every baud_div+1 cycles, and ends at its idle level. With cfg_cpha=0, data is sampled on the first (leading) transition of each bit and changed on the second. With cfg_cpha=1, data is changed on the leading transition and sampled on the trailing one.
- R4: With cfg_lsb_first=1, bit 0 of a byte goes first on both lines and the first received bit lands in bit 0. With cfg_lsb_first=0, bit 7 goes first and the first received bit lands in bit 7.
- R5: `busy` is high for the whole transfer. `tx_done` is set at the edge where the byte completes and is cleared by any host write.
- R6: The write side holds one byte. A byte written while a transfer runs is kept, and `tx_irq` pulses for one cycle when a held byte is taken into the shifter.
- R7: A write made while a byte is already held is ignored: the held byte is unchanged, the ignored byte is never sent, and `overrun` pulses in the cycle after that write.
- R8: With cfg_cpha=0, a held byte starts at the same edge where the previous byte ends. `busy` stays high, and `tx_irq` coincides with the previous byte's `rx_irq`.
- R9: With cfg_cpha=1, every byte is followed by a gap in which `busy` is low and `sck` rests at its idle level. A held byte starts baud_div+2 cycles after the previous byte ends.
- R10: A synchronous active-low reset sets `sck` to cfg_cpol, clears `busy`, `tx_done`, the interrupts, `overrun` and `rd_data`, and discards any held byte.
- R11: Outside a transfer, `sck` follows cfg_cpol within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading transition, 1: sample on trailing transition |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| baud_div | input | DIV_W | Half-bit length minus one, in system clock cycles |
| wr_en | input | 1 | Host write strobe for the data register |
| wr_data | input | DATA_W | Byte to transmit |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| rd_data | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| tx_done | output | 1 | Transfer finished since the last write |
| tx_irq | output | 1 | One-cycle pulse when a held byte is taken |
| rx_irq | output | 1 | One-cycle pulse when a received byte is ready |
| overrun | output | 1 | One-cycle pulse after an ignored write |

## Verification
A bench-side slave model tracks `sck` transitions, samples `mosi` and drives `miso` for every mode and bit order. Random bytes and settings are compared against values the bench computes. If the phase were off by one transition, or the bit order were mirrored, the bytes received on either side would come out shifted or reversed. Directed cases cover back-to-back bytes in both phases: a design that restarted too early with cfg_cpha=1 would show no idle gap, and one that stalled with cfg_cpha=0 would drop `busy` between the bytes. Further cases cover a write into a full buffer, which a faulty design would send as a third byte or use to overwrite the held byte, and a reset in the middle of a byte, after which a faulty design would still launch the discarded held byte.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RUN  = 2'd1,
      ENG_GAP  = 2'd2
   } eng_state_t;

endpackage

// File: rtl/spi_bm_baud.sv
module spi_bm_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == div) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == div);

endmodule

// File: rtl/spi_bm_hold.sv
module spi_bm_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data,
   output logic              overrun
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
         overrun    <= 1'b0;
      end else begin
         overrun <= wr_en && hold_valid;
         if (take) begin
            hold_valid <= 1'b0;
         end else if (wr_en && !hold_valid) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
         end
      end
   end

   AST_TAKE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> hold_valid) else $error("take with empty buffer"); // R6

   AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hold_valid && !take) |=> ($stable(hold_data) && hold_valid))
      else $error("held byte disturbed by ignored write"); // R7

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine
   import spi_bm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              hold_valid,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              miso,
   output logic              take,
   output logic              run,
   output logic              sck,
   output logic              mosi,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              tx_done,
   output logic              tx_irq,
   output logic              rx_irq
);

   localparam int HALF_W = $clog2(2 * DATA_W);
   localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * DATA_W - 1);

   eng_state_t        state_q;
   logic [HALF_W-1:0] half_q;
   logic [DATA_W-1:0] tx_sr_q;
   logic [DATA_W-1:0] rx_sr_q;
   logic [DATA_W-1:0] rx_shifted;
   logic [DATA_W-1:0] rx_fin;
   logic [DATA_W-1:0] hold_rev;
   logic [DATA_W-1:0] rx_rev;
   logic              cpha_q;
   logic              lsb_q;
   logic              in_run;
   logic              lead_edge;
   logic              sample_edge;
   logic              shift_edge;
   logic              end_edge;
   logic              start_now;

   always_comb begin
      in_run      = (state_q == ENG_RUN);
      lead_edge   = ~half_q[0];
      sample_edge = in_run && tick && (lead_edge ^ cpha_q);
      shift_edge  = in_run && tick && !(lead_edge ^ cpha_q)
                    && (half_q != '0) && (half_q != HALF_LAST);
      end_edge    = in_run && tick && (half_q == HALF_LAST);
      start_now   = hold_valid && ((state_q == ENG_IDLE) || (end_edge && !cpha_q));
      rx_shifted  = {rx_sr_q[DATA_W-2:0], miso};
      rx_fin      = sample_edge ? rx_shifted : rx_sr_q;
   end

   // Internal shifting is always toward the top bit; LSB-first mirrors at both ends.
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mirror
      assign hold_rev[gi] = hold_data[DATA_W-1-gi];
      assign rx_rev[gi]   = rx_fin[DATA_W-1-gi];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         half_q  <= '0;
         tx_sr_q <= '0;
         rx_sr_q <= '0;
         rd_data <= '0;
         cpha_q  <= 1'b0;
         lsb_q   <= 1'b0;
         sck     <= cfg_cpol;
         busy    <= 1'b0;
         tx_done <= 1'b0;
         tx_irq  <= 1'b0;
         rx_irq  <= 1'b0;
      end else begin
         tx_irq <= start_now;
         rx_irq <= end_edge;
         if (sample_edge) rx_sr_q <= rx_shifted;
         if (shift_edge)  tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
         if (in_run && tick) half_q <= half_q + 1'b1;
         if (end_edge) begin
            rd_data <= lsb_q ? rx_rev : rx_fin;
            tx_done <= 1'b1;
         end
         if (wr_en) tx_done <= 1'b0;
         unique case (state_q)
            ENG_IDLE: sck <= cfg_cpol;
            ENG_RUN: begin
               if (tick) sck <= ~sck;
               if (end_edge) begin
                  busy    <= 1'b0;
                  state_q <= cpha_q ? ENG_GAP : ENG_IDLE;
               end
            end
            ENG_GAP: begin
               sck <= cfg_cpol;
               if (tick) state_q <= ENG_IDLE;
            end
            default: state_q <= ENG_IDLE;
         endcase
         if (start_now) begin
            tx_sr_q <= cfg_lsb_first ? hold_rev : hold_data;
            cpha_q  <= cfg_cpha;
            lsb_q   <= cfg_lsb_first;
            half_q  <= '0;
            busy    <= 1'b1;
            sck     <= cfg_cpol;
            state_q <= ENG_RUN;
         end
      end
   end

   assign take = start_now;
   assign run  = (state_q != ENG_IDLE);
   assign mosi = tx_sr_q[DATA_W-1];

   AST_TXIRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> busy) else $error("take pulse outside a transfer"); // R6

   AST_DONE_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> rx_irq) else $error("done without receive pulse"); // R5

   AST_RX_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(busy)) else $error("receive pulse without transfer"); // R2

   AST_RX_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(tick)) else $error("byte ended off a baud tick"); // R3

   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $stable(cfg_cpol)) |-> (sck == cfg_cpol))
      else $error("serial clock away from idle level"); // R11

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lsb_first,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              tx_done,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic              overrun
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div_w
      $error("DIV_W must be at least 1");
   end

   logic              tick;
   logic              run;
   logic              take;
   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;

   spi_bm_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .take       (take),
      .hold_valid (hold_valid),
      .hold_data  (hold_data),
      .overrun    (overrun)
   );

   spi_bm_baud #(.DIV_W(DIV_W)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (baud_div),
      .tick  (tick)
   );

   spi_bm_engine #(.DATA_W(DATA_W)) u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_cpol      (cfg_cpol),
      .cfg_cpha      (cfg_cpha),
      .cfg_lsb_first (cfg_lsb_first),
      .tick          (tick),
      .wr_en         (wr_en),
      .hold_valid    (hold_valid),
      .hold_data     (hold_data),
      .miso          (miso),
      .take          (take),
      .run           (run),
      .sck           (sck),
      .mosi          (mosi),
      .rd_data       (rd_data),
      .busy          (busy),
      .tx_done       (tx_done),
      .tx_irq        (tx_irq),
      .rx_irq        (rx_irq)
   );

endmodule

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       t_cpol = 1'b0, t_cpha = 1'b0, t_lsb = 1'b0;
   logic [7:0] t_div = 8'd1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       miso;
   logic       sck, mosi, busy, tx_done, tx_irq, rx_irq, overrun;
   logic [7:0] rd_data;

   int         n_chk = 0, n_fail = 0;
   bit         mon_en = 1'b0;
   logic       prev_sck = 1'b0;
   logic [7:0] s_tx [0:63];
   logic [7:0] s_got [0:63];
   logic [7:0] s_acc = 8'd0;
   int         s_idx = 0, s_edges = 0, s_bit = 0;

   always #2.5 clk = ~clk;

   spi_byte_master u0 (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(t_cpol), .cfg_cpha(t_cpha),
      .cfg_lsb_first(t_lsb), .baud_div(t_div), .wr_en(wr_en), .wr_data(wr_data),
      .miso(miso), .sck(sck), .mosi(mosi), .rd_data(rd_data), .busy(busy),
      .tx_done(tx_done), .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun)
   );

   function automatic logic bitof(input logic [7:0] b, input int i, input logic lsb);
      return lsb ? b[i] : b[7-i];
   endfunction

   // Slave model: samples mosi on the sampling transition, drives miso on the other.
   always @(negedge clk) begin
      if (mon_en && (sck !== prev_sck)) begin
         if ((sck != t_cpol) ^ t_cpha) begin
            if (t_lsb) s_acc[s_bit] = mosi; else s_acc[7-s_bit] = mosi;
            s_bit++;
         end else if (s_bit < 8) begin
            miso = bitof(s_tx[s_idx], s_bit, t_lsb);
         end
         s_edges++;
         if (s_edges == 16) begin
            s_got[s_idx] = s_acc;
            s_idx++;
            s_edges = 0;
            s_bit = 0;
            miso = bitof(s_tx[s_idx], 0, t_lsb);
         end
      end else if (s_edges == 0) begin
         miso = bitof(s_tx[s_idx], 0, t_lsb);
      end
      prev_sck = sck;
   end

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input logic pol, input logic pha, input logic lsb, input int dv);
      mon_en = 1'b0;
      t_cpol = pol; t_cpha = pha; t_lsb = lsb; t_div = 8'(dv);
      repeat (3) @(negedge clk);
      chk_eq("R11", "idle sck level", sck, pol);
      mon_en = 1'b1;
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic run_one(input logic [7:0] d, input logic [7:0] s);
      int k, cyc;
      k = s_idx; s_tx[k] = s;
      host_write(d);
      chk_eq("R5", "tx_done cleared by write", tx_done, 0);
      @(negedge clk);
      chk_eq("R1", "busy after launch", busy, 1);
      chk_eq("R6", "tx_irq on take", tx_irq, 1);
      cyc = 0;
      while (rx_irq !== 1'b1) begin @(negedge clk); cyc++; end
      chk_eq("R1", "launch to rx_irq cycles", cyc, 16 * (t_div + 1));
      chk_eq("R2", "rd_data from slave", rd_data, s);
      chk_eq("R5", "tx_done at end", tx_done, 1);
      chk_eq("R5", "busy low at end", busy, 0);
      @(negedge clk);
      chk_eq("R4", "byte seen by slave", s_got[k], d);
      chk_eq("R3", "16 sck transitions", s_idx, k + 1);
      chk_eq("R3", "sck back at idle", sck, t_cpol);
      repeat (t_div + 4) @(negedge clk);
   endtask

   task automatic back_to_back(input logic [7:0] d1, input logic [7:0] s1,
                               input logic [7:0] d2, input logic [7:0] s2);
      int k, cyc, bad;
      k = s_idx; s_tx[k] = s1; s_tx[k+1] = s2;
      host_write(d1);
      while (tx_irq !== 1'b1) @(negedge clk);
      wr_en = 1'b1; wr_data = d2;
      @(negedge clk); wr_en = 1'b0;
      while (rx_irq !== 1'b1) @(negedge clk);
      chk_eq("R2", "first byte received", rd_data, s1);
      if (!t_cpha) begin
         chk_eq("R8", "busy held across bytes", busy, 1);
         chk_eq("R8", "tx_irq with rx_irq", tx_irq, 1);
      end else begin
         chk_eq("R9", "busy low in gap", busy, 0);
         cyc = 0; bad = 0;
         while (tx_irq !== 1'b1) begin
            @(negedge clk); cyc++;
            if (tx_irq !== 1'b1 && sck !== t_cpol) bad++;
         end
         chk_eq("R9", "restart delay", cyc, t_div + 2);
         chk_eq("R9", "sck idle in gap", bad, 0);
      end
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (rx_irq !== 1'b1);
      chk_eq("R1", "second byte length", cyc, 16 * (t_div + 1));
      chk_eq("R2", "second byte received", rd_data, s2);
      @(negedge clk);
      chk_eq("R4", "slave got first", s_got[k], d1);
      chk_eq("R4", "slave got second", s_got[k+1], d2);
      repeat (t_div + 4) @(negedge clk);
   endtask

   task automatic overrun_case(input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3);
      int k, bad;
      k = s_idx; s_tx[k] = 8'h5A; s_tx[k+1] = 8'hC3; s_tx[k+2] = 8'h00;
      host_write(d1);
      while (tx_irq !== 1'b1) @(negedge clk);
      wr_en = 1'b1; wr_data = d2;
      @(negedge clk); wr_data = d3;
      @(negedge clk); wr_en = 1'b0;
      chk_eq("R7", "overrun pulse", overrun, 1);
      @(negedge clk);
      chk_eq("R7", "overrun single cycle", overrun, 0);
      while (rx_irq !== 1'b1) @(negedge clk);
      @(negedge clk);
      while (rx_irq !== 1'b1) @(negedge clk);
      chk_eq("R7", "held byte answer", rd_data, 8'hC3);
      bad = 0;
      repeat (20 * (t_div + 1) + 5) begin @(negedge clk); if (busy) bad++; end
      chk_eq("R7", "no third transfer", bad, 0);
      chk_eq("R7", "slave byte count", s_idx, k + 2);
      chk_eq("R7", "held byte kept", s_got[k+1], d2);
   endtask

   initial begin
      int bad;
      for (int i = 0; i < 64; i++) s_tx[i] = 8'h00;
      void'($urandom(32'h1D2C3B4A));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_eq("R10", "reset sck", sck, 0);
      chk_eq("R10", "reset busy", busy, 0);
      chk_eq("R10", "reset tx_done", tx_done, 0);
      chk_eq("R10", "reset rd_data", rd_data, 0);
      chk_eq("R10", "reset irqs", {tx_irq, rx_irq, overrun}, 0);

      set_cfg(0, 0, 0, 1); run_one(8'hA5, 8'h3C);
      set_cfg(0, 0, 1, 0); run_one(8'h01, 8'h80);
      set_cfg(1, 1, 0, 2); run_one(8'h96, 8'h0F);
      set_cfg(1, 0, 1, 3); run_one(8'hFF, 8'h00);
      set_cfg(0, 0, 1, 1); back_to_back(8'h12, 8'hE1, 8'h34, 8'h7E);
      set_cfg(1, 1, 0, 2); back_to_back(8'hC8, 8'h55, 8'h3B, 8'hA0);
      set_cfg(0, 0, 0, 0); overrun_case(8'h11, 8'h22, 8'h33);

      for (int i = 0; i < 30; i++) begin
         set_cfg(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 6));
         run_one(8'($urandom), 8'($urandom));
      end

      // Reset in the middle of a byte with a second byte held (R10)
      set_cfg(1, 0, 0, 3);
      host_write(8'h6D);
      while (tx_irq !== 1'b1) @(negedge clk);
      host_write(8'h9E);
      repeat (10) @(negedge clk);
      mon_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk_eq("R10", "mid reset sck idle", sck, 1);
      chk_eq("R10", "mid reset busy", busy, 0);
      chk_eq("R10", "mid reset tx_done", tx_done, 0);
      chk_eq("R10", "mid reset rd_data", rd_data, 0);
      bad = 0;
      repeat (80) begin @(negedge clk); if (busy || sck !== 1'b1) bad++; end
      chk_eq("R10", "held byte discarded", bad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule